// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned 16-bit operands into a 32-bit product. It reuses a single adder across many clock cycles. The design has two parts. A datapath holds the captured multiplicand, a multiplier shift register, a 32-bit accumulator, an iteration counter and the result register. A one-hot control sequencer drives the datapath through a small bundle of action strobes.

The multiplier bits are examined from the most significant bit downward. Whenever the bit under test is set, the multiplicand is added into the accumulator. The accumulator and the multiplier register then both move one place to the left, except after the final bit. A caller presents operands and pulses `start` while `done` is high. It then waits for `done` to come back, and reads the product on `zOut` one cycle later. The product stays on `zOut` until the next multiply finishes.

Top module: `shift_add_mul`

## Requirements
- R1: After each multiply, `zOut` equals the full unsigned 32-bit product of the two captured operands, for every operand pair including 0xFFFF times 0xFFFF (0xFFFE0001).
- R2: A synchronous active-high `rst` makes `done` read 1 and `zOut` read 0 from the cycle after the reset edge. This also holds when reset arrives in the middle of a multiply.
- R3: The multiplier is scanned from bit 15 down to bit 0. The accumulator shifts left between consecutive bits but not after bit 0. As a result, a product of two single-bit operands 2^j and 2^k appears exactly at bit j+k.
- R4: Once `start` is accepted, `done` stays low for exactly 48 + (number of one bits in Y) cycles, which is between 48 and 64 cycles. It is high in every other cycle.
- R5: `done` first goes high in a finishing cycle, and `zOut` still shows the old product during that cycle. The new product appears on `zOut` in the next cycle.
- R6: `start` has no effect while `done` is low or during the finishing cycle. It does not restart the multiply, does not change the latency and does not change the result.
- R7: X and Y are captured in the cycle after `start` is accepted, and any later change to them has no effect on the result. `zOut` holds its value between completions.
- R8: If `start` is held high, a new multiply begins from the idle cycle that follows each finishing cycle. Each run keeps the full latency of R4, and `done` is high for two cycles between runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiply; only sampled when idle |
| xIn | input | 16 | Multiplicand |
| yIn | input | 16 | Multiplier |
| zOut | output | 32 | Product register |
| done | output | 1 | High when idle or finishing |

## Verification
The assertions rely on three things about the inputs. First, `start` is only meaningful when the sequencer is idle. Second, X and Y stay steady from the cycle in which `start` is sampled through the following load cycle. Third, `rst` is the only way to abandon a multiply. The stimulus respects these assumptions. It raises `start` only when the reference model is idle, except in the deliberate ignored-start and held-start cases. It keeps the operands steady for two cycles after `start` and only scrambles them later, while the sequencer is busy. A reference model of the cycle count and product, written from the requirements, is compared with `done` and `zOut` on every clock.

// File: rtl/sam_pkg.sv
package sam_pkg;

  // Actions the sequencer may request from the datapath in one cycle.
  typedef struct packed {
    logic loadA;     // capture multiplicand
    logic loadB;     // capture multiplier
    logic clearAcc;  // zero the accumulator
    logic clearCnt;  // zero the iteration counter
    logic incCnt;    // advance the iteration counter
    logic addAcc;    // accumulator += multiplicand
    logic shiftAcc;  // accumulator <<= 1
    logic shiftB;    // multiplier register <<= 1
    logic loadZ;     // publish accumulator to the result register
  } samStrobe_t;

  // One-hot state bit positions; the sequence order is behaviour.
  localparam int ST_IDLE   = 0;
  localparam int ST_LOAD   = 1;
  localparam int ST_TEST   = 2;
  localparam int ST_ADD    = 3;
  localparam int ST_CHECK  = 4;
  localparam int ST_SHIFT  = 5;
  localparam int ST_FINISH = 6;
  localparam int NUM_STATES = 7;

endpackage

// File: rtl/sam_control.sv
module sam_control
  import sam_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       topBit,
  input  logic       cntDone,
  output samStrobe_t strobe,
  output logic       done
);

  logic [NUM_STATES-1:0] stateQ;
  logic [NUM_STATES-1:0] stateD;

  // Next-state logic: exactly one bit of stateD is set.
  always_comb begin
    stateD = '0;
    if (stateQ[ST_IDLE]) begin
      if (start) stateD[ST_LOAD] = 1'b1;
      else       stateD[ST_IDLE] = 1'b1;
    end else if (stateQ[ST_LOAD]) begin
      stateD[ST_TEST] = 1'b1;
    end else if (stateQ[ST_TEST]) begin
      if (topBit) stateD[ST_ADD]   = 1'b1;
      else        stateD[ST_CHECK] = 1'b1;
    end else if (stateQ[ST_ADD]) begin
      stateD[ST_CHECK] = 1'b1;
    end else if (stateQ[ST_CHECK]) begin
      if (cntDone) stateD[ST_FINISH] = 1'b1;
      else         stateD[ST_SHIFT]  = 1'b1;
    end else if (stateQ[ST_SHIFT]) begin
      stateD[ST_TEST] = 1'b1;
    end else begin
      // finishing state, or an illegal pattern: return to idle
      stateD[ST_IDLE] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ          <= '0;
      stateQ[ST_IDLE] <= 1'b1;
    end else begin
      stateQ <= stateD;
    end
  end

  // Strobe decode: one state bit per group of actions.
  always_comb begin
    strobe          = '0;
    strobe.loadA    = stateQ[ST_LOAD];
    strobe.loadB    = stateQ[ST_LOAD];
    strobe.clearAcc = stateQ[ST_LOAD];
    strobe.clearCnt = stateQ[ST_LOAD];
    strobe.incCnt   = stateQ[ST_TEST];
    strobe.addAcc   = stateQ[ST_ADD];
    strobe.shiftAcc = stateQ[ST_SHIFT];
    strobe.shiftB   = stateQ[ST_SHIFT];
    strobe.loadZ    = stateQ[ST_FINISH];
  end

  assign done = stateQ[ST_IDLE] | stateQ[ST_FINISH];

  AST_ONE_HOT_STATE: assert property (@(posedge clk) disable iff (rst)
    $countones(stateQ) == 1); // R4

  AST_LOAD_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    strobe.loadA |-> ($past(done) && $past(start))); // R6

  AST_FINISH_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    strobe.loadZ |=> (done && !strobe.loadZ)); // R5

endmodule

// File: rtl/sam_datapath.sv
module sam_datapath
  import sam_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  samStrobe_t        strobe,
  input  logic [OP_W-1:0]   xIn,
  input  logic [OP_W-1:0]   yIn,
  output logic              topBit,
  output logic              cntDone,
  output logic [2*OP_W-1:0] zOut
);

  localparam int ACC_W = 2 * OP_W;
  localparam int CNT_W = $clog2(OP_W) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OP_W);

  logic [OP_W-1:0]  aQ;
  logic [OP_W-1:0]  bQ;
  logic [ACC_W-1:0] accQ;
  logic [CNT_W-1:0] cntQ;
  logic [ACC_W-1:0] zQ;
  logic [ACC_W-1:0] addend;

  assign addend = {{(ACC_W-OP_W){1'b0}}, aQ};

  // Operand registers
  always_ff @(posedge clk) begin
    if (rst) begin
      aQ <= '0;
      bQ <= '0;
    end else begin
      if (strobe.loadA) aQ <= xIn;
      if (strobe.loadB)       bQ <= yIn;
      else if (strobe.shiftB) bQ <= {bQ[OP_W-2:0], 1'b0};
    end
  end

  // Accumulator: carry out of the top bit is discarded
  always_ff @(posedge clk) begin
    if (rst)                  accQ <= '0;
    else if (strobe.clearAcc) accQ <= '0;
    else if (strobe.addAcc)   accQ <= accQ + addend;
    else if (strobe.shiftAcc) accQ <= {accQ[ACC_W-2:0], 1'b0};
  end

  // Iteration counter
  always_ff @(posedge clk) begin
    if (rst)                  cntQ <= '0;
    else if (strobe.clearCnt) cntQ <= '0;
    else if (strobe.incCnt)   cntQ <= cntQ + 1'b1;
  end

  // Result register
  always_ff @(posedge clk) begin
    if (rst)               zQ <= '0;
    else if (strobe.loadZ) zQ <= accQ;
  end

  assign topBit  = bQ[OP_W-1];
  assign cntDone = (cntQ >= CNT_LAST);
  assign zOut    = zQ;

  AST_Z_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadZ |=> $stable(zQ)); // R7

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cntQ <= CNT_LAST); // R3

  AST_NO_SHIFT_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    strobe.shiftAcc |-> (cntQ < CNT_LAST)); // R3

  AST_ADD_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    strobe.addAcc |=> (accQ >= $past(accQ))); // R1

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import sam_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   xIn,
  input  logic [OP_W-1:0]   yIn,
  output logic [2*OP_W-1:0] zOut,
  output logic              done
);

  localparam int BUSY_MAX = 4 * OP_W;
  localparam int RUN_W    = $clog2(BUSY_MAX + 2) + 1;

  samStrobe_t strobe;
  logic       topBit;
  logic       cntDone;

  sam_control u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .topBit  (topBit),
    .cntDone (cntDone),
    .strobe  (strobe),
    .done    (done)
  );

  sam_datapath #(.OP_W(OP_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .xIn     (xIn),
    .yIn     (yIn),
    .topBit  (topBit),
    .cntDone (cntDone),
    .zOut    (zOut)
  );

  // Length of the current busy stretch, kept only for the latency bound.
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (rst || done) busyRun <= '0;
    else             busyRun <= busyRun + 1'b1;
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busyRun <= RUN_W'(BUSY_MAX)); // R4

endmodule

// File: tb/shift_add_mul_test.sv
`timescale 1ns/1ps
module shift_add_mul_test;

  localparam int OP_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [OP_W-1:0]   xIn = '0;
  logic [OP_W-1:0]   yIn = '0;
  logic [2*OP_W-1:0] zOut;
  logic              done;

  always #2 clk = ~clk;

  shift_add_mul #(.OP_W(OP_W)) uut (
    .clk(clk), .rst(rst), .start(start), .xIn(xIn), .yIn(yIn),
    .zOut(zOut), .done(done)
  );

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  string curTag = "R2";

  typedef enum {PH_IDLE, PH_BUSY, PH_FIN} phase_e;
  phase_e      ph = PH_IDLE;
  int          left = 0;
  logic [31:0] pend = '0;
  logic [31:0] expZ = '0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", curTag, what, act, exp);
    end
  endtask

  // Behavioural reference: a busy countdown and the arithmetic product.
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      ph   = PH_IDLE;
      expZ = '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph   = PH_BUSY;
          left = 48 + $countones(yIn);   // R4
          pend = 32'(xIn) * 32'(yIn);    // R1
        end
        PH_BUSY: begin
          left--;
          if (left == 0) ph = PH_FIN;
        end
        default: begin
          ph   = PH_IDLE;
          expZ = pend;                   // R5
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("done", 32'(done), 32'(ph != PH_BUSY));
      chk("zOut", zOut, expZ);
    end
  end

  task automatic waitIdle();
    while (ph != PH_IDLE) @(negedge clk);
  endtask

  task automatic runMul(input logic [15:0] x, input logic [15:0] y, input string tag);
    waitIdle();
    curTag = tag;
    xIn = x; yIn = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    xIn = 16'($urandom); yIn = 16'($urandom);   // R7: after capture
    waitIdle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curTag = "R2";
    chk("reset done", 32'(done), 32'd1);
    chk("reset zOut", zOut, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    runMul(16'h0000, 16'h0000, "R1");
    runMul(16'h0001, 16'h0001, "R1");
    runMul(16'hFFFF, 16'hFFFF, "R1");
    chk("max product", zOut, 32'hFFFE0001);
    runMul(16'h0000, 16'hFFFF, "R4");
    runMul(16'hFFFF, 16'h0001, "R5");
    runMul(16'h1234, 16'h0000, "R4");
    for (int j = 0; j < OP_W; j += 3) begin
      for (int k = 0; k < OP_W; k += 5) begin
        runMul(16'(1 << j), 16'(1 << k), "R3");
        chk("single bit", zOut, 32'(1) << (j + k));
      end
    end
    for (int n = 0; n < 40; n++) runMul(16'($urandom), 16'($urandom), "R1");

    // R6: start pulses while busy are ignored
    waitIdle();
    curTag = "R6";
    xIn = 16'hBEEF; yIn = 16'hA5A5; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); xIn = 16'h0001; yIn = 16'h0001;
    repeat (4) @(negedge clk);
    start = 1'b1; repeat (2) @(negedge clk); start = 1'b0;
    waitIdle(); @(negedge clk);
    chk("ignored start", zOut, 32'(16'hBEEF) * 32'(16'hA5A5));

    // R8: start held high gives back-to-back runs
    curTag = "R8";
    xIn = 16'h00FF; yIn = 16'h8001; start = 1'b1;
    repeat (150) @(negedge clk);
    start = 1'b0;
    waitIdle(); @(negedge clk);
    chk("held start", zOut, 32'h007F80FF);

    // R2: reset in the middle of a multiply
    curTag = "R2";
    xIn = 16'h0F0F; yIn = 16'hF0F0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("mid reset done", 32'(done), 32'd1);
    chk("mid reset zOut", zOut, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    runMul(16'h0F0F, 16'hF0F0, "R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog act=%0d exp=<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule